// File: doc/BRIEF.md
# Programmable Software Watchdog with Optional Prescaler

This block watches over system software. A 16-bit down-counter, run from the system clock, counts toward expiry from a time-out value that software chooses. If software does not service the watchdog before the count runs out, the block raises a one-clock request. That request goes either to the reset controller or to the non-maskable machine-check interrupt, as software selects. When long periods are needed, a divide-by-65,536 prescaler can be switched in ahead of the counter.

Software works through three register addresses. The control word holds the enable, the prescale enable, the request routing and the time-out count. The service address takes a two-write unlock sequence. The count address returns the live counter value. A new time-out value does not disturb the running count. It takes effect only on the next complete service sequence. After reset, the enable comes from an external configuration pin, so the watchdog can be armed from the first cycle.

Top module: `soft_watchdog`

## Requirements
- R1: Synchronous reset (rstN low at a clock edge) sets the time-out count to 0xFFFF and the live count to 0xFFFF. It clears prescale enable, sets the routing bit to reset (1), and loads enable from cfgEnable. No request pulse is issued during or right after reset. The control word reads back with enable in bit 2, prescale enable in bit 1, routing in bit 0 (1 = reset, 0 = interrupt) and the time-out count in bits 31:16.
- R2: While enabled with the prescaler off, the live count falls by one on every clock edge until it reaches 1.
- R3: When the counter takes a step while it holds 1 (or 0), it reloads from the time-out count and keeps running. In the same edge a request is registered that is high for exactly one clock. It appears on rstReq when the routing bit is 1 and on irqReq when it is 0, and never on both.
- R4: Writing the control word changes the stored time-out count but leaves the running count untouched.
- R5: A write of 0x556C to the service address (1), followed directly by a write of 0xAA39 there, loads the live count from the time-out count and clears the prescaler. The next request follows exactly time-out × divide clocks later. This reload also happens while the watchdog is disabled.
- R6: The sequence is abandoned without a reload in three cases: another write comes between the two service writes, the second service value is wrong, or 0xAA39 is written without the first write.
- R7: While enable is 0, the live count and the prescaler stay frozen.
- R8: With prescale enabled, the counter steps once every PRE_DIV clocks (65,536 by default), counted from the last service reload.
- R9: Writes to the count address (2) have no effect on the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgEnable | input | 1 | Enable value taken at reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 service, 2 count |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Read address, combinational read |
| rdData | output | 32 | Read data for rdAddr |
| rstReq | output | 1 | One-clock reset request on expiry |
| irqReq | output | 1 | One-clock machine-check request on expiry |

## Verification
The bound checker watches several rules on every cycle. It checks that the reset state appears, that a prescaler-free step lowers the count by one, and that a service strobe loads the time-out value. It checks that a disabled counter holds still, and that each request goes out on the routing chosen in the cycle before, never on both outputs. Other properties depend on whole sequences, and only the bench scenarios can show them. These are the full period to expiry after a service, the aborted unlock sequences, the prescaled period, the untouched count after a time-out rewrite, and the ignored writes to the count address.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SVC  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd2;

  localparam int BIT_SEL = 0;
  localparam int BIT_PRE = 1;
  localparam int BIT_EN  = 2;
  localparam int TO_LSB  = 16;

  typedef struct packed {
    logic reload;
    logic run;
    logic usePre;
    logic toReset;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [15:0] KEY_ARM  = 16'h556C,
  parameter logic [15:0] KEY_FIRE = 16'hAA39
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  output wdtStrobe_t        strb,
  output logic [CNT_W-1:0]  timeoutVal,
  output logic [REG_W-1:0]  ctrlWord
);
  logic [CNT_W-1:0] toQ;
  logic enQ, preQ, selQ, armQ;
  logic svcWrite, ctrlWrite;

  assign svcWrite  = wrEn && (wrAddr == ADDR_SVC);
  assign ctrlWrite = wrEn && (wrAddr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toQ  <= '1;
      enQ  <= cfgEnable;
      preQ <= 1'b0;
      selQ <= 1'b1;
      armQ <= 1'b0;
    end else begin
      if (wrEn) armQ <= svcWrite && (wrData[15:0] == KEY_ARM);
      if (ctrlWrite) begin
        toQ  <= wrData[TO_LSB +: CNT_W];
        enQ  <= wrData[BIT_EN];
        preQ <= wrData[BIT_PRE];
        selQ <= wrData[BIT_SEL];
      end
    end
  end

  always_comb begin
    strb.reload  = svcWrite && armQ && (wrData[15:0] == KEY_FIRE);
    strb.run     = enQ;
    strb.usePre  = preQ;
    strb.toReset = selQ;
  end

  assign timeoutVal = toQ;

  always_comb begin
    ctrlWord = '0;
    ctrlWord[BIT_SEL] = selQ;
    ctrlWord[BIT_PRE] = preQ;
    ctrlWord[BIT_EN]  = enQ;
    ctrlWord[TO_LSB +: CNT_W] = toQ;
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_DIV = 65536
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       strb,
  input  logic [CNT_W-1:0] timeoutVal,
  output logic [CNT_W-1:0] count,
  output logic             rstPulse,
  output logic             irqPulse
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic tick;
  logic [CNT_W-1:0] cntQ;

  generate
    if (PRE_DIV > 1) begin : g_prescale
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || strb.reload)
          preCnt <= '0;
        else if (strb.run && strb.usePre)
          preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
      end
      assign tick = strb.run && (!strb.usePre || (preCnt == PRE_LAST));
    end else begin : g_noPrescale
      assign tick = strb.run;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ     <= '1;
      rstPulse <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      rstPulse <= 1'b0;
      irqPulse <= 1'b0;
      if (strb.reload) begin
        cntQ <= timeoutVal;
      end else if (tick) begin
        if (cntQ <= ONE) begin
          cntQ     <= timeoutVal;
          rstPulse <= strb.toReset;
          irqPulse <= !strb.toReset;
        end else begin
          cntQ <= cntQ - 1'b1;
        end
      end
    end
  end

  assign count = cntQ;
endmodule

// File: rtl/soft_watchdog.sv
module soft_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_DIV = 65536,
  parameter logic [15:0] KEY_ARM  = 16'h556C,
  parameter logic [15:0] KEY_FIRE = 16'hAA39
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgEnable,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [1:0]  rdAddr,
  output logic [31:0] rdData,
  output logic        rstReq,
  output logic        irqReq
);
  wdtStrobe_t       strb;
  logic [CNT_W-1:0] timeoutVal;
  logic [CNT_W-1:0] count;
  logic [REG_W-1:0] ctrlWord;

  wdt_ctrl #(.CNT_W(CNT_W), .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .strb(strb),
    .timeoutVal(timeoutVal), .ctrlWord(ctrlWord)
  );

  wdt_datapath #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .timeoutVal(timeoutVal),
    .count(count), .rstPulse(rstReq), .irqPulse(irqReq)
  );

  always_comb begin
    case (rdAddr)
      ADDR_CTRL: rdData = ctrlWord;
      ADDR_CNT:  rdData = REG_W'(count);
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/soft_watchdog_chk.sv
module soft_watchdog_chk
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             rstReq,
  input logic             irqReq,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] timeoutVal,
  input wdtStrobe_t       strb
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (count == '1) && !rstReq && !irqReq);

  // R2
  step_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.usePre && !strb.reload && count > CNT_W'(1))
      |=> count == CNT_W'($past(count) - 1'b1));

  // R3
  one_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rstReq && irqReq));

  // R3
  rst_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $past(strb.toReset));

  // R3
  irq_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> !$past(strb.toReset));

  // R5
  service_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> count == $past(timeoutVal));

  // R7
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.reload) |=> $stable(count));
endmodule

bind soft_watchdog soft_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .rstReq(rstReq), .irqReq(irqReq),
  .count(count), .timeoutVal(timeoutVal), .strb(strb)
);

// File: tb/test_soft_watchdog.sv
module test_soft_watchdog;
  localparam int PRE_DIV = 8;
  localparam logic [15:0] KA = 16'h556C;
  localparam logic [15:0] KB = 16'hAA39;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnable = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [31:0] wrData = '0;
  logic [1:0] rdAddr = 2'd2;
  logic [31:0] rdData;
  logic rstReq, irqReq;

  int checks = 0;
  int fails = 0;
  bit cmpOn = 1'b0;

  soft_watchdog #(.PRE_DIV(PRE_DIV)) i_soft_watchdog (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .rstReq(rstReq), .irqReq(irqReq)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model of the requirements
  logic [15:0] mTo, mCnt;
  logic mEn, mPre, mSel, mArm, mRst, mIrq;
  int mPc;
  bit mTick, mRel;

  always @(posedge clk) begin
    if (!rstN) begin
      mTo <= 16'hFFFF; mCnt <= 16'hFFFF; mEn <= cfgEnable; mPre <= 1'b0;
      mSel <= 1'b1; mArm <= 1'b0; mRst <= 1'b0; mIrq <= 1'b0; mPc <= 0;
    end else begin
      mRel = wrEn && wrAddr == 2'd1 && mArm && wrData[15:0] == KB;
      if (wrEn) mArm <= (wrAddr == 2'd1) && (wrData[15:0] == KA);
      if (wrEn && wrAddr == 2'd0) begin
        mTo <= wrData[31:16]; mEn <= wrData[2]; mPre <= wrData[1]; mSel <= wrData[0];
      end
      mRst <= 1'b0; mIrq <= 1'b0;
      mTick = 1'b0;
      if (mRel) begin
        mCnt <= mTo; mPc <= 0;
      end else if (mEn) begin
        if (mPre) begin
          if (mPc == PRE_DIV - 1) begin mPc <= 0; mTick = 1'b1; end
          else mPc <= mPc + 1;
        end else mTick = 1'b1;
        if (mTick) begin
          if (mCnt <= 16'd1) begin
            mCnt <= mTo;
            if (mSel) mRst <= 1'b1; else mIrq <= 1'b1;
          end else mCnt <= mCnt - 16'd1;
        end
      end
    end
  end

  // Cycle-by-cycle comparison, sampled mid high phase
  always @(posedge clk) begin
    #2;
    if (cmpOn) begin
      check("R3 rstReq vs model", {31'b0, rstReq}, {31'b0, mRst});
      check("R3 irqReq vs model", {31'b0, irqReq}, {31'b0, mIrq});
      if (rdAddr == 2'd2) check("R2 count vs model", rdData, {16'h0, mCnt});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rdAddr = a;
    #1 d = rdData;
    rdAddr = 2'd2;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog timeout actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, r;
    int n;
    void'($urandom(32'd4242));
    @(posedge clk); #1 cmpOn = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(2'd0, r); check("R1 control after reset", r, 32'hFFFF_0001);
    rd(2'd2, r); check("R1 count after reset", r, 32'h0000_FFFF);

    // R9 write to count ignored; R7 held while disabled
    wr(2'd2, 32'h0000_1234);
    rd(2'd2, r); check("R9 count write ignored", r, 32'h0000_FFFF);
    repeat (5) @(negedge clk);
    rd(2'd2, r); check("R7 disabled count frozen", r, 32'h0000_FFFF);

    // R4 new time-out does not disturb running count
    wr(2'd0, 32'h000A_0005);
    rd(2'd2, r); check("R4 running count kept", {31'b0, r > 32'd10}, 32'd1);

    // R5 service then full period to expiry on reset route
    wr(2'd1, {16'h0, KA});
    wr(2'd1, {16'h0, KB});
    #1 check("R5 reload value", rdData, 32'd10);
    n = 0;
    while (!rstReq && n < 100) begin
      @(negedge clk); #1 n++;
      if (n == 4) check("R2 step per clock", rdData, 32'd6);
    end
    check("R5 period to expiry", n, 32'd10);
    check("R3 reload after expiry", rdData, 32'd10);
    check("R3 no irq on reset route", {31'b0, irqReq}, 32'd0);
    @(negedge clk); #1 check("R3 pulse one clock", {31'b0, rstReq}, 32'd0);

    // R7 / R6 with the counter stopped
    wr(2'd0, 32'h000A_0001);
    rd(2'd2, v);
    repeat (5) @(negedge clk);
    rd(2'd2, r); check("R7 stopped count", r, v);
    wr(2'd1, {16'h0, KA}); wr(2'd0, 32'h000A_0001); wr(2'd1, {16'h0, KB});
    rd(2'd2, r); check("R6 interleaved write aborts", r, v);
    wr(2'd1, {16'h0, KA}); wr(2'd1, 32'h0000_1111); wr(2'd1, {16'h0, KB});
    rd(2'd2, r); check("R6 wrong second value aborts", r, v);
    wr(2'd1, {16'h0, KB});
    rd(2'd2, r); check("R6 lone second write ignored", r, v);
    wr(2'd1, {16'h0, KA}); wr(2'd1, {16'h0, KB});
    rd(2'd2, r); check("R5 reload while disabled", r, 32'd10);

    // R8 prescaled period, interrupt route
    wr(2'd0, 32'h0003_0006);
    wr(2'd1, {16'h0, KA}); wr(2'd1, {16'h0, KB});
    #1 n = 0;
    while (!irqReq && n < 200) begin
      @(negedge clk); #1 n++;
      if (n == 7) check("R8 held before divide", rdData, 32'd3);
      if (n == 8) check("R8 step after divide", rdData, 32'd2);
    end
    check("R8 prescaled period", n, 32'd24);
    check("R3 no reset on irq route", {31'b0, rstReq}, 32'd0);

    // Random mix checked against the model
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 8;
      case (op)
        0: wr(2'd0, {16'(1 + $urandom % 40), 13'b0, 1'($urandom % 4 != 0),
                     1'($urandom % 6 == 0), 1'($urandom % 2)});
        1, 2, 3: begin wr(2'd1, {16'h0, KA}); wr(2'd1, {16'h0, KB}); end
        4: begin wr(2'd1, {16'h0, KA}); wr(2'd1, $urandom); wr(2'd1, {16'h0, KB}); end
        5: wr(2'd2, $urandom);
        6: repeat ($urandom % 30) @(negedge clk);
        default: begin wr(2'd1, {16'h0, KA}); wr(2'd2, 32'h0); wr(2'd1, {16'h0, KB}); end
      endcase
    end

    // R1 enable taken from configuration pin
    cfgEnable = 1'b1;
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    rd(2'd0, r); check("R1 enable from cfg pin", r, 32'hFFFF_0005);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule